// File: doc/BRIEF.md
# I2C Write-Only Master with Host-Paced Byte Stream

This block drives a two-wire serial bus as a write-only master. The host places a byte in a one-entry transmit holding register. If the bus is idle, that write starts a transfer: the block sends a START condition, then the 7-bit device address given on an input port, a write direction bit and an acknowledge slot. After each acknowledged byte, the waiting holding byte moves into the shift register and goes out most-significant bit first. When no byte is waiting, the block holds the clock line low and waits. The bus never drops back to idle between bytes on its own.

A transfer ends only in two ways. The host can pulse a STOP command, which takes effect after the current byte's acknowledge. A byte that is already waiting is sent before the STOP. The other way is a not-acknowledge from the target, which makes the block discard the waiting byte and end the transfer by itself. Both bus lines are modelled as open-drain: an active-low enable pulls the line down, and a release lets the external pull-up raise it. Three status flags feed one interrupt output through an enable mask: holding register free, transfer complete and not-acknowledged.

Top module: `iic_tx_master`

## Requirements
- R1: After reset both bus enables are released (`scl_oe_n_o`=1, `sda_oe_n_o`=1), `tx_ready_o`=1, `tx_done_o`=1, `nack_o`=0 and, with `irq_en_i`=0, `irq_o`=0.
- R2: A holding-register write while idle starts a transfer. SDA falls while SCL is released (START). Then the address goes out MSB first, followed by a 0 write bit, then a released ninth bit in which SDA is sampled. `tx_done_o` goes to 0 within three clocks of the write.
- R3: Each acknowledged byte is followed by the next held byte, sent MSB first. While a bit is shifting, SDA changes only while SCL is driven low.
- R4: `tx_ready_o` goes to 0 on a holding-register write. It stays 0 until that byte moves into the shift register at an acknowledge, and otherwise stays 1.
- R5: After an acknowledge, if no byte is waiting and no STOP is pending, `scl_oe_n_o` stays 0 for as long as the host does nothing.
- R6: While SCL is held low in that wait, a holding-register write releases SCL within 20 clocks and the byte is sent.
- R7: A STOP occurs only after a host STOP command, at the first acknowledge after it. A waiting byte is sent before a pending STOP. A STOP command while idle has no effect on the bus or the flags.
- R8: In a STOP, SDA rises while SCL is released. `tx_done_o` returns to 1 only after that.
- R9: A high SDA in the ninth bit sets `nack_o` and drops any waiting byte (`tx_ready_o`=1). It also produces a STOP with no host command. `nack_o` clears when the next transfer starts.
- R10: `irq_o` is the OR of the flags whose enable bit is set: `irq_en_i[0]` for `tx_ready_o`, `[1]` for `tx_done_o`, `[2]` for `nack_o`.
- R11: One quarter bit lasts `clk_div_i`+1 clocks. Each bit keeps SCL released for two quarters, so SCL is high for 2·(`clk_div_i`+1) clocks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| dev_addr_i | input | 7 | Target device address |
| hold_we_i | input | 1 | Write strobe for the transmit holding register |
| hold_data_i | input | 8 | Byte written to the holding register |
| stop_cmd_i | input | 1 | STOP command pulse |
| clk_div_i | input | 16 | Quarter-bit divider, the quarter lasts value+1 clocks |
| irq_en_i | input | 3 | Interrupt enables {nack, done, ready} |
| sda_in_i | input | 1 | Sensed level of the data line |
| scl_oe_n_o | output | 1 | Clock line pull-down enable, active low |
| sda_oe_n_o | output | 1 | Data line pull-down enable, active low |
| tx_ready_o | output | 1 | Holding register free |
| tx_done_o | output | 1 | No transfer in progress, last STOP completed |
| nack_o | output | 1 | Last transfer ended on a not-acknowledge |
| irq_o | output | 1 | Masked OR of the status flags |

## Verification
Two decisions can fall in the same clock: taking in a waiting byte and acting on a pending STOP at the acknowledge. The bench provokes this by writing the next byte and pulsing the STOP command in the same clock while the previous byte is on the wire. A byte-level scoreboard then requires both bytes on the wire before the STOP marker. A second collision is a not-acknowledge that arrives while a byte is waiting. The bench judges it by the absence of that byte on the wire, a free holding register and the set `nack_o` flag.

// File: rtl/iic_tx_pkg.sv
// Package: shared state encoding and one-cycle event bundle for the
// write-only two-wire master. Assumes one clock domain for all users.
package iic_tx_pkg;

    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_START = 3'd1,
        ST_BIT   = 3'd2,
        ST_WAIT  = 3'd3,
        ST_STOP  = 3'd4
    } iic_state_e;

    // Single-cycle strobes from the bit engine to the status block.
    typedef struct packed {
        logic start;    // transfer begins (START driven)
        logic load;     // holding byte moved into the shifter
        logic ack;      // ninth bit sampled low
        logic nack;     // ninth bit sampled high
        logic stop_go;  // STOP sequence begins
        logic done;     // STOP sequence finished, bus free
    } iic_evt_t;

    localparam int NUM_FLAGS = 3;

endpackage

// File: rtl/iic_tick_gen.sv
// Quarter-bit tick generator.
// Produces a one-clock tick every div_i+1 clocks while en_i is high and
// restarts from zero whenever en_i is low, so the first quarter after a
// transfer starts is always full length. Assumes div_i is quasi-static.
module iic_tick_gen #(
    parameter int DIV_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en_i,
    input  logic [DIV_W-1:0] div_i,
    output logic             tick_o
);

    logic [DIV_W-1:0] cnt_q;
    logic             wrap;

    assign wrap   = (cnt_q >= div_i);
    assign tick_o = en_i && wrap;

    // Count clocks within the current quarter; hold at zero when disabled.
    always_ff @(posedge clk) begin
        if (!rst_n || !en_i) begin
            cnt_q <= '0;
        end else if (wrap) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    // A nonzero divider never yields ticks on two adjacent clocks.
    AST_TICK_SPACING: assert property (@(posedge clk) disable iff (!rst_n)
        (tick_o && div_i != '0) |=> (!tick_o || div_i == '0)); // R11

endmodule

// File: rtl/iic_bit_engine.sv
// Bit-level sequencer for the write-only master.
// Forms START, shifts address and data bytes MSB first in four quarters per
// bit (SCL low, low, high, high), samples the ninth bit at the end of its
// last quarter, parks with SCL low when nothing is waiting, and forms STOP.
// Assumes hold/stop inputs come from registers in the same clock domain and
// sda_in_i is already synchronised. Every move except leaving idle waits for
// a quarter tick.
module iic_bit_engine
    import iic_tx_pkg::*;
#(
    parameter int ADDR_W = 7,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_i,
    input  logic              hold_full_i,
    input  logic [DATA_W-1:0] hold_data_i,
    input  logic              stop_pend_i,
    input  logic [ADDR_W-1:0] dev_addr_i,
    input  logic              sda_in_i,
    output iic_state_e        state_o,
    output logic              scl_low_o,
    output logic              sda_low_o,
    output iic_evt_t          evt_o
);

    localparam int BIT_W = $clog2(DATA_W + 1);
    localparam logic [BIT_W-1:0] ACK_SLOT = BIT_W'(DATA_W);
    localparam logic [1:0] Q0 = 2'd0;
    localparam logic [1:0] Q1 = 2'd1;
    localparam logic [1:0] Q2 = 2'd2;
    localparam logic [1:0] Q3 = 2'd3;

    iic_state_e        state_q;
    logic [1:0]        qtr_q;
    logic [BIT_W-1:0]  bit_q;
    logic [DATA_W-1:0] shift_q;
    logic              scl_low_q;
    logic              sda_low_q;
    logic              last_bit;
    logic              ack_slot;
    logic              wait_tick;

    assign last_bit  = (bit_q == ACK_SLOT);
    assign ack_slot  = (state_q == ST_BIT) && tick_i && (qtr_q == Q3) && last_bit;
    assign wait_tick = (state_q == ST_WAIT) && tick_i;

    // Decode the one-cycle events the status block reacts to.
    always_comb begin
        evt_o         = '0;
        evt_o.start   = (state_q == ST_IDLE) && hold_full_i;
        evt_o.ack     = ack_slot && !sda_in_i;
        evt_o.nack    = ack_slot && sda_in_i;
        evt_o.load    = ((evt_o.ack || wait_tick) && hold_full_i);
        evt_o.stop_go = evt_o.nack
                      || ((evt_o.ack || wait_tick) && !hold_full_i && stop_pend_i);
        evt_o.done    = (state_q == ST_STOP) && tick_i && (qtr_q == Q3);
    end

    // Sequence state, quarter/bit counters, shifter and the two line drives.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q   <= ST_IDLE;
            qtr_q     <= Q0;
            bit_q     <= '0;
            shift_q   <= '0;
            scl_low_q <= 1'b0;
            sda_low_q <= 1'b0;
        end else begin
            unique case (state_q)
                ST_IDLE: begin
                    if (hold_full_i) begin
                        state_q   <= ST_START;
                        sda_low_q <= 1'b1;
                        qtr_q     <= Q0;
                        shift_q   <= {dev_addr_i, 1'b0};
                    end
                end
                ST_START: begin
                    if (tick_i) begin
                        state_q   <= ST_BIT;
                        qtr_q     <= Q0;
                        bit_q     <= '0;
                        scl_low_q <= 1'b1;
                    end
                end
                ST_BIT: begin
                    if (tick_i) begin
                        qtr_q <= qtr_q + 1'b1;
                        unique case (qtr_q)
                            Q0: sda_low_q <= last_bit ? 1'b0 : ~shift_q[DATA_W-1];
                            Q1: scl_low_q <= 1'b0;
                            Q2: ;
                            Q3: begin
                                scl_low_q <= 1'b1;
                                qtr_q     <= Q0;
                                if (!last_bit) begin
                                    shift_q <= shift_q << 1;
                                    bit_q   <= bit_q + 1'b1;
                                end else if (sda_in_i) begin
                                    state_q <= ST_STOP;
                                end else if (hold_full_i) begin
                                    shift_q <= hold_data_i;
                                    bit_q   <= '0;
                                end else if (stop_pend_i) begin
                                    state_q <= ST_STOP;
                                end else begin
                                    state_q <= ST_WAIT;
                                end
                            end
                            default: ;
                        endcase
                    end
                end
                ST_WAIT: begin
                    if (tick_i) begin
                        qtr_q <= Q0;
                        if (hold_full_i) begin
                            state_q <= ST_BIT;
                            shift_q <= hold_data_i;
                            bit_q   <= '0;
                        end else if (stop_pend_i) begin
                            state_q <= ST_STOP;
                        end
                    end
                end
                ST_STOP: begin
                    if (tick_i) begin
                        qtr_q <= qtr_q + 1'b1;
                        unique case (qtr_q)
                            Q0: sda_low_q <= 1'b1;
                            Q1: scl_low_q <= 1'b0;
                            Q2: sda_low_q <= 1'b0;
                            Q3: begin
                                state_q <= ST_IDLE;
                                qtr_q   <= Q0;
                            end
                            default: ;
                        endcase
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    assign state_o   = state_q;
    assign scl_low_o = scl_low_q;
    assign sda_low_o = sda_low_q;

    // While shifting, SDA must not move across a clock-high stretch.
    AST_SDA_STABLE_SCL_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_BIT && $past(state_q) == ST_BIT && !scl_low_q && !$past(scl_low_q))
        |-> $stable(sda_low_q)); // R3
    // Parking after an acknowledge keeps the clock line pulled down.
    AST_WAIT_HOLDS_SCL: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_WAIT) |-> scl_low_q); // R5
    // A not-acknowledge leads straight into the STOP sequence.
    AST_NACK_THEN_STOP: assert property (@(posedge clk) disable iff (!rst_n)
        evt_o.nack |=> (state_q == ST_STOP)); // R9
    // Leaving the parked state for STOP needs a host command.
    AST_STOP_NEEDS_CMD: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(state_q) == ST_WAIT && state_q == ST_STOP) |-> $past(stop_pend_i)); // R7
    // Transfer start, byte load, not-acknowledge and completion are exclusive.
    AST_EVT_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({evt_o.start, evt_o.load, evt_o.nack, evt_o.done})); // R3

endmodule

// File: rtl/iic_tx_status.sv
// Host-side holding register, pending STOP and status flags.
// Keeps the one-entry transmit holding register, remembers a STOP command
// given during a transfer, and maintains the ready / complete /
// not-acknowledge flags plus the masked interrupt. Assumes events come from
// the bit engine of the same clock domain. A host write in the same clock
// as a byte load keeps the new byte.
module iic_tx_status
    import iic_tx_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 hold_we_i,
    input  logic [DATA_W-1:0]    hold_data_i,
    input  logic                 stop_cmd_i,
    input  logic                 busy_i,
    input  iic_evt_t             evt_i,
    input  logic [NUM_FLAGS-1:0] irq_en_i,
    output logic                 hold_full_o,
    output logic [DATA_W-1:0]    hold_data_o,
    output logic                 stop_pend_o,
    output logic                 tx_ready_o,
    output logic                 tx_done_o,
    output logic                 nack_o,
    output logic                 irq_o
);

    logic                 full_q;
    logic [DATA_W-1:0]    data_q;
    logic                 stop_q;
    logic                 done_q;
    logic                 nack_q;
    logic [NUM_FLAGS-1:0] flags;

    // Holding register: host write fills it; load or not-acknowledge empties it.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            full_q <= 1'b0;
            data_q <= '0;
        end else if (hold_we_i) begin
            full_q <= 1'b1;
            data_q <= hold_data_i;
        end else if (evt_i.load || evt_i.nack) begin
            full_q <= 1'b0;
        end
    end

    // Pending STOP: only accepted mid-transfer, consumed when STOP begins.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stop_q <= 1'b0;
        end else if (evt_i.stop_go || evt_i.done) begin
            stop_q <= 1'b0;
        end else if (stop_cmd_i && busy_i) begin
            stop_q <= 1'b1;
        end
    end

    // Completion and not-acknowledge flags, both cleared by a new START.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            done_q <= 1'b1;
            nack_q <= 1'b0;
        end else if (evt_i.start) begin
            done_q <= 1'b0;
            nack_q <= 1'b0;
        end else begin
            if (evt_i.done) done_q <= 1'b1;
            if (evt_i.nack) nack_q <= 1'b1;
        end
    end

    assign flags       = {nack_q, done_q, ~full_q};
    assign hold_full_o = full_q;
    assign hold_data_o = data_q;
    assign stop_pend_o = stop_q;
    assign tx_ready_o  = ~full_q;
    assign tx_done_o   = done_q;
    assign nack_o      = nack_q;
    assign irq_o       = |(flags & irq_en_i);

    // Ready stays set until the host writes a byte.
    AST_READY_UNTIL_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_ready_o && !hold_we_i) |=> tx_ready_o); // R4
    // A new START clears the completion flag.
    AST_DONE_CLEARED_AT_START: assert property (@(posedge clk) disable iff (!rst_n)
        evt_i.start |=> !tx_done_o); // R2
    // Completion rises only when the STOP sequence ends.
    AST_DONE_ONLY_AFTER_STOP: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(tx_done_o) |-> $past(evt_i.done)); // R8
    // A not-acknowledge discards the waiting byte.
    AST_NACK_DROPS_BYTE: assert property (@(posedge clk) disable iff (!rst_n)
        (evt_i.nack && !hold_we_i) |=> (tx_ready_o && nack_o)); // R9

endmodule

// File: rtl/iic_tx_master.sv
// Top of the write-only two-wire master.
// Ties the quarter-tick divider, the bit engine and the host status block
// together, synchronises the sensed data line with two flops and turns the
// engine's pull-down requests into active-low open-drain enables. Assumes
// external pull-ups and a target that does not stretch the clock.
module iic_tx_master
    import iic_tx_pkg::*;
#(
    parameter int ADDR_W = 7,
    parameter int DATA_W = 8,
    parameter int DIV_W  = 16
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [ADDR_W-1:0]    dev_addr_i,
    input  logic                 hold_we_i,
    input  logic [DATA_W-1:0]    hold_data_i,
    input  logic                 stop_cmd_i,
    input  logic [DIV_W-1:0]     clk_div_i,
    input  logic [NUM_FLAGS-1:0] irq_en_i,
    input  logic                 sda_in_i,
    output logic                 scl_oe_n_o,
    output logic                 sda_oe_n_o,
    output logic                 tx_ready_o,
    output logic                 tx_done_o,
    output logic                 nack_o,
    output logic                 irq_o
);

    iic_state_e        state;
    iic_evt_t          evt;
    logic              tick;
    logic              hold_full;
    logic [DATA_W-1:0] hold_data;
    logic              stop_pend;
    logic              scl_low;
    logic              sda_low;
    logic              sda_s1_q;
    logic              sda_s2_q;
    logic              busy;

    assign busy = (state != ST_IDLE);

    // Two-flop synchroniser on the sensed data line, idles high.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sda_s1_q <= 1'b1;
            sda_s2_q <= 1'b1;
        end else begin
            sda_s1_q <= sda_in_i;
            sda_s2_q <= sda_s1_q;
        end
    end

    iic_tick_gen #(.DIV_W(DIV_W)) u_tick (
        .clk    (clk),
        .rst_n  (rst_n),
        .en_i   (busy),
        .div_i  (clk_div_i),
        .tick_o (tick)
    );

    iic_bit_engine #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_engine (
        .clk         (clk),
        .rst_n       (rst_n),
        .tick_i      (tick),
        .hold_full_i (hold_full),
        .hold_data_i (hold_data),
        .stop_pend_i (stop_pend),
        .dev_addr_i  (dev_addr_i),
        .sda_in_i    (sda_s2_q),
        .state_o     (state),
        .scl_low_o   (scl_low),
        .sda_low_o   (sda_low),
        .evt_o       (evt)
    );

    iic_tx_status #(.DATA_W(DATA_W)) u_status (
        .clk         (clk),
        .rst_n       (rst_n),
        .hold_we_i   (hold_we_i),
        .hold_data_i (hold_data_i),
        .stop_cmd_i  (stop_cmd_i),
        .busy_i      (busy),
        .evt_i       (evt),
        .irq_en_i    (irq_en_i),
        .hold_full_o (hold_full),
        .hold_data_o (hold_data),
        .stop_pend_o (stop_pend),
        .tx_ready_o  (tx_ready_o),
        .tx_done_o   (tx_done_o),
        .nack_o      (nack_o),
        .irq_o       (irq_o)
    );

    assign scl_oe_n_o = ~scl_low;
    assign sda_oe_n_o = ~sda_low;

    // An idle master leaves both lines to the pull-ups.
    AST_IDLE_RELEASES_BUS: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_done_o && !busy) |-> (scl_oe_n_o && sda_oe_n_o)); // R7

endmodule

// File: tb/iic_tx_master_tb_top.sv
// Scoreboard bench: tasks push expected bytes / STOP markers into a queue and
// a behavioural open-drain target pops and compares what it sees on the wire.
module iic_tx_master_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam logic [8:0] STOP_MARK = 9'h100;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [6:0]  dev_addr = 7'h2A;
    logic        hold_we = 1'b0;
    logic [7:0]  hold_data = 8'h00;
    logic        stop_cmd = 1'b0;
    logic [15:0] clk_div = 16'd1;
    logic [2:0]  irq_en = 3'b000;
    logic        scl_oe_n, sda_oe_n, tx_ready, tx_done, nack, irq;
    logic        slv_low = 1'b0;
    logic        scl_line, sda_line;

    int n_checks = 0;
    int n_errors = 0;
    logic [8:0] exp_q[$];

    // Open-drain wiring with pull-ups.
    assign scl_line = scl_oe_n;
    assign sda_line = sda_oe_n & ~slv_low;

    always #(CLK_PERIOD/2) clk = ~clk;

    iic_tx_master dut_i (
        .clk(clk), .rst_n(rst_n), .dev_addr_i(dev_addr), .hold_we_i(hold_we),
        .hold_data_i(hold_data), .stop_cmd_i(stop_cmd), .clk_div_i(clk_div),
        .irq_en_i(irq_en), .sda_in_i(sda_line), .scl_oe_n_o(scl_oe_n),
        .sda_oe_n_o(sda_oe_n), .tx_ready_o(tx_ready), .tx_done_o(tx_done),
        .nack_o(nack), .irq_o(irq)
    );

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic expect_item(input logic [8:0] item);
        exp_q.push_back(item);
    endtask

    // Behavioural target: decodes START/STOP, shifts bits, acknowledges.
    logic       prev_scl = 1'b1, prev_sda = 1'b1;
    logic       in_xfer = 1'b0;
    int         bitcnt = 0;
    int         byte_idx = 0;
    int         nack_idx = -1;
    logic [7:0] rx = 8'h00;
    logic [8:0] want;

    always @(negedge clk) begin
        if (rst_n) begin
            if (scl_line && prev_scl && prev_sda && !sda_line) begin
                in_xfer = 1'b1; bitcnt = 0; byte_idx = 0; rx = 8'h00;
            end else if (scl_line && prev_scl && !prev_sda && sda_line) begin
                in_xfer = 1'b0;
                want = (exp_q.size() > 0) ? exp_q.pop_front() : 9'h1FF;
                chk(want == STOP_MARK, "R7 R8 STOP position in stream", STOP_MARK, want);
            end else if (!prev_scl && scl_line && in_xfer) begin
                if (bitcnt < 8) rx = {rx[6:0], sda_line};
                bitcnt++;
            end else if (prev_scl && !scl_line && in_xfer) begin
                if (bitcnt == 8) begin
                    want = (exp_q.size() > 0) ? exp_q.pop_front() : 9'h1FF;
                    chk(want == {1'b0, rx}, "R2 R3 byte on wire", {1'b0, rx}, want);
                    slv_low = (byte_idx != nack_idx);
                    byte_idx++;
                end else if (bitcnt == 9) begin
                    slv_low = 1'b0;
                    bitcnt = 0;
                end
            end
        end
        prev_scl = scl_line;
        prev_sda = sda_line;
    end

    task automatic write_byte(input logic [7:0] b);
        @(negedge clk); hold_we = 1'b1; hold_data = b;
        @(negedge clk); hold_we = 1'b0;
    endtask

    task automatic pulse_stop();
        @(negedge clk); stop_cmd = 1'b1;
        @(negedge clk); stop_cmd = 1'b0;
    endtask

    task automatic wait_ready(input string tag);
        int t = 0;
        while (!tx_ready && t < 5000) begin @(negedge clk); t++; end
        chk(tx_ready == 1'b1, tag, tx_ready, 1);
    endtask

    task automatic wait_done(input string tag);
        int t = 0;
        repeat (4) @(negedge clk);
        while (!tx_done && t < 10000) begin @(negedge clk); t++; end
        chk(tx_done == 1'b1, tag, tx_done, 1);
    endtask

    task automatic measure_high(output int n);
        int t = 0;
        n = 0;
        while (scl_line && t < 2000) begin @(negedge clk); t++; end
        while (!scl_line && t < 4000) begin @(negedge clk); t++; end
        while (scl_line && t < 6000) begin @(negedge clk); t++; n++; end
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        n_errors++;
        $display("FAIL watchdog expired");
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end

    initial begin : main
        int hi;
        int cnt;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk(scl_oe_n == 1'b1, "R1 scl released", scl_oe_n, 1);
        chk(sda_oe_n == 1'b1, "R1 sda released", sda_oe_n, 1);
        chk(tx_ready == 1'b1, "R1 ready", tx_ready, 1);
        chk(tx_done == 1'b1, "R1 done", tx_done, 1);
        chk(nack == 1'b0, "R1 nack", nack, 0);
        chk(irq == 1'b0, "R1 irq", irq, 0);

        // R7 STOP command while idle: no bus activity, flags unchanged
        pulse_stop();
        repeat (30) @(negedge clk);
        chk(scl_oe_n && sda_oe_n, "R7 idle stop leaves bus", {scl_oe_n, sda_oe_n}, 2'b11);
        chk(tx_done == 1'b1, "R7 idle stop done flag", tx_done, 1);

        // Single data byte, STOP requested during the address byte
        dev_addr = 7'h2A; clk_div = 16'd1;
        expect_item(9'h054); expect_item(9'h0A5); expect_item(STOP_MARK);
        write_byte(8'hA5);
        repeat (3) @(negedge clk);
        chk(tx_done == 1'b0, "R2 done cleared at start", tx_done, 0);
        chk(tx_ready == 1'b0, "R4 ready low after write", tx_ready, 0);
        measure_high(hi);
        chk(hi == 4, "R11 scl high time div=1", hi, 4);
        pulse_stop();
        wait_done("R8 done after stop");
        chk(tx_ready == 1'b1, "R4 ready after byte taken", tx_ready, 1);
        chk(nack == 1'b0, "R9 no nack on acked transfer", nack, 0);

        // Parked clock, then resume on a host write
        dev_addr = 7'h51; clk_div = 16'd3;
        expect_item(9'h0A2); expect_item(9'h03C); expect_item(9'h0C3); expect_item(STOP_MARK);
        write_byte(8'h3C);
        measure_high(hi);
        chk(hi == 8, "R11 scl high time div=3", hi, 8);
        repeat (600) @(negedge clk);
        chk(scl_oe_n == 1'b0, "R5 scl held low while waiting", scl_oe_n, 0);
        cnt = 0;
        for (int i = 0; i < 100; i++) begin @(negedge clk); if (scl_oe_n) cnt++; end
        chk(cnt == 0, "R5 scl never released while waiting", cnt, 0);
        chk(tx_done == 1'b0, "R5 transfer still open", tx_done, 0);
        write_byte(8'hC3);
        cnt = 0;
        while (!scl_oe_n && cnt < 20) begin @(negedge clk); cnt++; end
        chk(scl_oe_n == 1'b1, "R6 write releases scl", scl_oe_n, 1);
        pulse_stop();
        wait_done("R8 done after parked transfer");

        // Same-clock byte write and STOP command: byte first, then STOP
        dev_addr = 7'h2A; clk_div = 16'd1;
        expect_item(9'h054); expect_item(9'h011); expect_item(9'h022); expect_item(STOP_MARK);
        write_byte(8'h11);
        wait_ready("R4 ready after address ack");
        @(negedge clk); hold_we = 1'b1; hold_data = 8'h22; stop_cmd = 1'b1;
        @(negedge clk); hold_we = 1'b0; stop_cmd = 1'b0;
        wait_done("R7 done after byte-then-stop");
        chk(tx_ready == 1'b1, "R7 pending byte consumed before stop", tx_ready, 1);

        // Not-acknowledge on first data byte with a byte waiting
        nack_idx = 1;
        expect_item(9'h054); expect_item(9'h05A); expect_item(STOP_MARK);
        write_byte(8'h5A);
        wait_ready("R4 ready before nack");
        write_byte(8'h77);
        wait_done("R9 automatic stop after nack");
        chk(nack == 1'b1, "R9 nack flag set", nack, 1);
        chk(tx_ready == 1'b1, "R9 waiting byte discarded", tx_ready, 1);
        irq_en = 3'b100; @(negedge clk);
        chk(irq == 1'b1, "R10 irq from nack", irq, 1);
        irq_en = 3'b000; @(negedge clk);
        chk(irq == 1'b0, "R10 irq masked", irq, 0);

        // Next transfer clears nack; done-only interrupt follows completion
        nack_idx = -1;
        irq_en = 3'b010;
        expect_item(9'h054); expect_item(9'h099); expect_item(STOP_MARK);
        write_byte(8'h99);
        repeat (6) @(negedge clk);
        chk(nack == 1'b0, "R9 nack cleared at start", nack, 0);
        chk(irq == 1'b0, "R10 irq low with enabled flag clear", irq, 0);
        pulse_stop();
        wait_done("R8 done final transfer");
        chk(irq == 1'b1, "R10 irq from done", irq, 1);
        irq_en = 3'b000;
        repeat (10) @(negedge clk);
        chk(exp_q.size() == 0, "R3 scoreboard drained", exp_q.size(), 0);

        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end

endmodule